// File: doc/BRIEF.md
# Normalizing Barrel Shifter Unit

This unit is the shift stage of a 16-bit fixed-point datapath. Each strobed operation takes a 16-bit word, places it in one half of a 32-bit field, and then runs one of five operations on it. Two are plain shifts: a logical shift that fills with zeros and an arithmetic shift that fills with copies of the sign. Three serve floating-point work: exponent detection, normalize and denormalize.

Exponent detection counts how many copies of the sign bit the word carries below its top bit. Normalize shifts the word left by that count, so the first significant bit lands directly under the sign. Denormalize shifts right by a supplied exponent, which turns a mantissa back into a fixed-point word.

A merge control ORs a new shift result into the previous 32-bit result. This allows a 32-bit value to be shifted in two steps, one per 16-bit half. Results and the exponent are registered and appear one clock after the strobe.

Top module: `nshift_unit`

## Requirements
- R1: After reset, `result` is 0, `exp_out` is 0 and `res_valid` is 0.
- R2: Opcode 0 is a logical shift. `sel_hi`=1 places `din` at bits 31:16 with zeros below. `sel_hi`=0 places it at bits 15:0 with zeros above. A non-negative `amt` (two's complement) shifts left and a negative `amt` shifts right by its magnitude. Vacated bits are zero.
- R3: Opcode 1 is an arithmetic shift. With `sel_hi`=0 the field is `din` sign-extended to 32 bits. Right shifts fill with bit 31 of the field and left shifts fill with zero.
- R4: A shift magnitude of 32 or more gives all zeros. The exception is an arithmetic right shift, which gives 32 copies of field bit 31.
- R5: Opcode 4 derives the exponent. `exp_out` becomes the number of consecutive bits, counted down from bit 14 of `din`, that equal bit 15. The value is 15 for an all-zero or all-one word. `result` is unchanged.
- R6: Opcode 2 normalizes. The field, placed as for opcode 1, is shifted left by the R5 count, and `exp_out` takes that count. `amt` is ignored.
- R7: Opcode 3 denormalizes. The field, placed as for opcode 1, is shifted right arithmetically by the magnitude of `amt`.
- R8: For opcodes 0 to 3 with `or_mode`=1, the new result is the bitwise OR of the shifted field and the previous `result`. With `or_mode`=0 the shifted field replaces it.
- R9: An operation is visible on `result`, `exp_out` and `res_valid` on the first rising edge after the clock edge at which `op_valid` was sampled high. `res_valid` is high for exactly that one cycle. Without a strobe, `result` and `exp_out` hold.
- R10: Opcodes 5 to 7 are ignored. `result` and `exp_out` hold, and `res_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (0 LSH, 1 ASH, 2 NORM, 3 DENORM, 4 EXP) |
| amt | input | 8 | Signed shift amount or exponent |
| sel_hi | input | 1 | Place `din` in the upper half of the field |
| or_mode | input | 1 | Merge the new result with the previous result |
| din | input | 16 | Data word |
| result | output | 32 | Registered shift result |
| exp_out | output | 4 | Registered redundant-sign count |
| res_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions watch several properties on every cycle:
- the one-cycle latency of `res_valid`;
- that `result` holds without a strobe;
- that `exp_out` holds outside exponent operations;
- that the result is all-zero for out-of-range logical shifts;
- that merged results never lose a bit;
- that a normalized upper-half result always has differing top two bits.

Exact bit values need the bench. These include sign fill at every magnitude, the placement of each half, exponent counts for corner words such as 0x0000, 0xFFFF and 0x8000, and the two-step 32-bit shift built from OR merges.

// File: rtl/nshift_pkg.sv
package nshift_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4
  } nshift_op_e;

  function automatic logic op_is_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/nshift_field.sv
// Places the input word in the high or low half of the shift field.
module nshift_field #(
  parameter int DATA_W = 16,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic              sel_hi,
  input  logic              sign_ext,
  output logic [RES_W-1:0]  field
);
  logic [DATA_W-1:0] upper_fill;
  assign upper_fill = (sign_ext && din[DATA_W-1]) ? '1 : '0;

  always_comb begin
    if (sel_hi) field = {din, {DATA_W{1'b0}}};
    else        field = {upper_fill, din};
  end
endmodule

// File: rtl/nshift_expdet.sv
// Counts redundant sign bits below the top bit of the word.
module nshift_expdet #(
  parameter int DATA_W = 16,
  localparam int EXP_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  output logic [EXP_W-1:0]  sign_run
);
  function automatic logic [EXP_W-1:0] redundant_signs(input logic [DATA_W-1:0] d);
    logic             run;
    logic [EXP_W-1:0] cnt;
    run = 1'b1;
    cnt = '0;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (run && (d[i] == d[DATA_W-1])) cnt = cnt + 1'b1;
      else                              run = 1'b0;
    end
    return cnt;
  endfunction

  assign sign_run = redundant_signs(din);
endmodule

// File: rtl/nshift_core.sv
// Log-depth barrel shifter with saturation for large magnitudes.
module nshift_core #(
  parameter int RES_W = 32,
  parameter int AMT_W = 8,
  localparam int STAGES = $clog2(RES_W)
) (
  input  logic [RES_W-1:0] field,
  input  logic             go_left,
  input  logic             fill_bit,
  input  logic [AMT_W-1:0] mag,
  output logic [RES_W-1:0] shifted
);
  logic [RES_W-1:0] stage [STAGES+1];
  logic             too_far;

  assign stage[0] = field;
  assign too_far  = |mag[AMT_W-1:STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [RES_W-1:0] moved;
    assign moved = go_left ? {stage[s][RES_W-STEP-1:0], {STEP{1'b0}}}
                           : {{STEP{fill_bit}}, stage[s][RES_W-1:STEP]};
    assign stage[s+1] = mag[s] ? moved : stage[s];
  end

  assign shifted = too_far ? (go_left ? '0 : {RES_W{fill_bit}}) : stage[STAGES];
endmodule

// File: rtl/nshift_unit.sv
module nshift_unit
  import nshift_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  localparam int RES_W = 2 * DATA_W,
  localparam int EXP_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [AMT_W-1:0]  amt,
  input  logic              sel_hi,
  input  logic              or_mode,
  input  logic [DATA_W-1:0] din,
  output logic [RES_W-1:0]  result,
  output logic [EXP_W-1:0]  exp_out,
  output logic              res_valid
);
  nshift_op_e       op;
  logic             legal_op;
  logic             shift_op;
  logic             exp_op;
  logic             arith;
  logic             go_left;
  logic [AMT_W-1:0] amt_mag;
  logic [AMT_W-1:0] mag;
  logic [RES_W-1:0] field;
  logic [RES_W-1:0] shifted;
  logic [RES_W-1:0] merged;
  logic [EXP_W-1:0] sign_run;
  logic             fill_bit;
  logic             din_all_sign;

  assign op       = nshift_op_e'(op_code);
  assign legal_op = op_is_legal(op_code);
  assign exp_op   = legal_op && (op == OP_NORM || op == OP_EXP);
  assign shift_op = legal_op && (op != OP_EXP);
  assign amt_mag  = amt[AMT_W-1] ? (~amt + 1'b1) : amt;

  always_comb begin
    arith   = 1'b1;
    go_left = 1'b1;
    mag     = '0;
    case (op)
      OP_LSH:    begin arith = 1'b0; go_left = ~amt[AMT_W-1]; mag = amt_mag; end
      OP_ASH:    begin go_left = ~amt[AMT_W-1]; mag = amt_mag; end
      OP_NORM:   mag = {{(AMT_W-EXP_W){1'b0}}, sign_run};
      OP_DENORM: begin go_left = 1'b0; mag = amt_mag; end
      default:   mag = '0;
    endcase
  end

  nshift_field #(.DATA_W(DATA_W)) u_field (
    .din(din), .sel_hi(sel_hi), .sign_ext(arith), .field(field)
  );

  nshift_expdet #(.DATA_W(DATA_W)) u_expdet (
    .din(din), .sign_run(sign_run)
  );

  assign fill_bit = arith & field[RES_W-1];

  nshift_core #(.RES_W(RES_W), .AMT_W(AMT_W)) u_core (
    .field(field), .go_left(go_left), .fill_bit(fill_bit), .mag(mag), .shifted(shifted)
  );

  assign merged       = or_mode ? (result | shifted) : shifted;
  assign din_all_sign = (din == '0) || (din == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      exp_out   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid && legal_op;
      if (op_valid && shift_op) result  <= merged;
      if (op_valid && exp_op)   exp_out <= sign_run;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal_op) |=> res_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && !res_valid)); // R9
  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && exp_op) |=> $stable(exp_out)); // R5
  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !legal_op) |=> (!res_valid && $stable(result))); // R10
  AST_FAR_LOGICAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && !or_mode && amt_mag >= AMT_W'(RES_W)) |=> (result == '0)); // R4
  AST_OR_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && shift_op && or_mode) |=> ((result & $past(result)) == $past(result))); // R8
  AST_NORM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2 && sel_hi && !or_mode && !din_all_sign)
      |=> (result[RES_W-1] != result[RES_W-2])); // R6
endmodule

// File: tb/nshift_unit_tb_top.sv
module nshift_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [7:0]  amt = '0;
  logic        sel_hi = 1'b0;
  logic        or_mode = 1'b0;
  logic [15:0] din = '0;
  logic [31:0] result;
  logic [3:0]  exp_out;
  logic        res_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_res = '0;
  logic [3:0]  m_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nshift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .amt(amt),
    .sel_hi(sel_hi), .or_mode(or_mode), .din(din), .result(result),
    .exp_out(exp_out), .res_valid(res_valid)
  );

  function automatic logic [31:0] ref_field(logic [15:0] d, bit hi, bit sx);
    if (hi) return {d, 16'h0000};
    if (sx) return {{16{d[15]}}, d};
    return {16'h0000, d};
  endfunction

  function automatic logic [31:0] ref_shift(logic [31:0] f, int s, bit ar);
    logic signed [31:0] sf;
    int n;
    sf = f;
    if (s >= 0) return (s >= 32) ? 32'h0 : (f << s);
    n = -s;
    if (n >= 32) return ar ? {32{f[31]}} : 32'h0;
    return ar ? 32'(sf >>> n) : (f >> n);
  endfunction

  function automatic logic [3:0] ref_exp(logic [15:0] d);
    int c = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      c++;
    end
    return 4'(c);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic [2:0] c, logic [7:0] a, bit hi, bit orm, logic [15:0] d, string req);
    int s;
    logic [31:0] shv;
    bit legal;
    s = $signed(a);
    legal = (c <= 3'd4);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; amt = a; sel_hi = hi; or_mode = orm; din = d;
    case (c)
      3'd0: shv = ref_shift(ref_field(d, hi, 1'b0), s, 1'b0);
      3'd1: shv = ref_shift(ref_field(d, hi, 1'b1), s, 1'b1);
      3'd2: shv = ref_shift(ref_field(d, hi, 1'b1), int'(ref_exp(d)), 1'b1);
      3'd3: shv = ref_shift(ref_field(d, hi, 1'b1), (s < 0) ? s : -s, 1'b1);
      default: shv = 32'h0;
    endcase
    if (c <= 3'd3) m_res = orm ? (m_res | shv) : shv;
    if (c == 3'd2 || c == 3'd4) m_exp = ref_exp(d);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    check(req, "result", result, m_res);
    check(req, "exp_out", {28'h0, exp_out}, {28'h0, m_exp});
    check("R9", "res_valid", {31'h0, res_valid}, {31'h0, legal});
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    string tag;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 2);
    check("R1", "result", result, 32'h0);
    check("R1", "exp_out", {28'h0, exp_out}, 32'h0);
    check("R1", "res_valid", {31'h0, res_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    run_op(3'd0, 8'd4, 1'b0, 1'b0, 16'h8421, "R2");
    run_op(3'd0, 8'hFC, 1'b1, 1'b0, 16'h8421, "R2");
    run_op(3'd1, 8'hF8, 1'b0, 1'b0, 16'h8001, "R3");
    run_op(3'd1, 8'd3, 1'b0, 1'b0, 16'hC000, "R3");
    run_op(3'd0, 8'd32, 1'b0, 1'b0, 16'hFFFF, "R4");
    run_op(3'd1, 8'hE0, 1'b1, 1'b0, 16'h8000, "R4");
    run_op(3'd1, 8'h80, 1'b0, 1'b0, 16'h1234, "R4");
    run_op(3'd4, 8'd0, 1'b0, 1'b0, 16'h0000, "R5");
    run_op(3'd4, 8'd0, 1'b0, 1'b0, 16'hFFFF, "R5");
    run_op(3'd4, 8'd0, 1'b0, 1'b0, 16'h8000, "R5");
    run_op(3'd4, 8'd0, 1'b0, 1'b0, 16'h0001, "R5");
    run_op(3'd2, 8'd7, 1'b1, 1'b0, 16'h0030, "R6");
    run_op(3'd2, 8'd0, 1'b1, 1'b0, 16'hFF80, "R6");
    run_op(3'd3, 8'd5, 1'b1, 1'b0, 16'hA000, "R7");
    run_op(3'd3, 8'hFB, 1'b1, 1'b0, 16'h6000, "R7");
    // R8: two-step 32-bit logical right shift by 4 of 0x1234ABCD
    run_op(3'd0, 8'hFC, 1'b1, 1'b0, 16'h1234, "R8");
    run_op(3'd0, 8'hFC, 1'b0, 1'b1, 16'hABCD, "R8");
    check("R8", "two-step", result, 32'h01234ABC);
    run_op(3'd5, 8'd3, 1'b0, 1'b0, 16'h7777, "R10");
    run_op(3'd7, 8'd1, 1'b1, 1'b1, 16'h0F0F, "R10");
    @(negedge clk);
    @(negedge clk);
    check("R9", "hold result", result, m_res);
    check("R9", "idle valid", {31'h0, res_valid}, 32'h0);

    for (int k = 0; k < 400; k++) begin
      logic [2:0] c;
      logic [7:0] a;
      c = 3'($urandom_range(0, 7));
      a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($signed($urandom_range(0, 40)) - 20);
      case (c)
        3'd0: tag = "R2";
        3'd1: tag = "R3";
        3'd2: tag = "R6";
        3'd3: tag = "R7";
        3'd4: tag = "R5";
        default: tag = "R10";
      endcase
      run_op(c, a, 1'($urandom), ($urandom_range(0, 3) == 0), 16'($urandom), tag);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule